// File: doc/BRIEF.md
# List-Driven Block Transfer Engine

This block is the transfer engine next to a processing element that owns a private local memory. Software hands it one command at a time. A get command copies data from the remote address space into local memory. A put command copies local data out to a remote address. Each command carries a tag. A command describes either one block, given by a local address, a remote address and a byte size, or a chain of blocks whose descriptors sit in local memory. The engine splits every block into 16-byte beats. For each beat it reads the source port and then writes the destination port. When the final write of the command has been acknowledged, it raises a one-cycle completion pulse that carries the tag and an error flag.

The local and remote memories each sit behind a simple request/response port, and only one request is in flight at any time. In list mode the command's size field holds the number of entries. The entries are fetched one by one from the list address. Each entry supplies its own remote address and byte size, and the local address simply keeps running from the end of the previous entry. Commands that cannot be carried out are refused when they are issued. Such a command moves no data and completes at once with the error flag set.

Top module: `blkxfer`

## Requirements
- R1: `cmdReady` is high only while the engine is idle. A command is taken on a cycle with `cmdValid` and `cmdReady` both high. `cmdReady` is low in the cycle after acceptance and stays low until the cycle after the completion pulse.
- R2: A single put (`cmdPut`=1, `cmdList`=0) reads local memory at `cmdLocalAddr`+16k and writes the same 16 bytes to remote memory at `cmdRemoteAddr`+16k, for k from 0 up to size/16-1, in ascending order.
- R3: A single get (`cmdPut`=0) reads remote memory at `cmdRemoteAddr`+16k and writes local memory at `cmdLocalAddr`+16k, in ascending order.
- R4: A single command is refused when its size is 0, is above 16384, or has a nonzero value in bits [3:0], or when bits [3:0] of the local or remote address are nonzero. A refused command issues no memory request, and its completion pulse comes with `doneErr`=1 in the cycle after acceptance.
- R5: In a list command (`cmdList`=1), `cmdSize` is the entry count. The command is refused, exactly as in R4, when the count is below 2 or above 2048, when bits [2:0] of `cmdListAddr` are nonzero, or when bits [3:0] of `cmdLocalAddr` are nonzero.
- R6: Entry i is an 8-byte descriptor at `cmdListAddr`+8i. It is fetched by a local read of the 16-byte-aligned address. The descriptor is bits [63:0] of the returned data when bit 3 of the entry address is 0, and bits [127:64] when it is 1. Within the descriptor, bits [31:0] hold the remote address and bits [63:32] hold the byte size.
- R7: The entries of a list run in order, like back-to-back single commands. Each entry uses its own remote address, and the local address continues from where the previous entry stopped.
- R8: A descriptor whose size is 0, above 16384 or not a multiple of 16, or whose remote address is not 16-byte aligned, ends the command with `doneErr`=1. That entry and every later entry move no data. Earlier entries still complete.
- R9: `doneValid` is a one-cycle pulse carrying the command's tag. For a successful command it comes with `doneErr`=0, and only after the last write of the command has been accepted and acknowledged.
- R10: At most one of the two ports has a request pending at any time. A request is held with an unchanged address until it is accepted.
- R11: During reset, `cmdReady` is 1 and `locReqValid`, `remReqValid` and `doneValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdPut | input | 1 | 1 = put (local to remote), 0 = get (remote to local) |
| cmdList | input | 1 | 1 = list command, 0 = single block |
| cmdTag | input | TAG_W | Tag returned with completion |
| cmdLocalAddr | input | LADDR_W | Local byte address (start of data) |
| cmdRemoteAddr | input | RADDR_W | Remote byte address (single only) |
| cmdListAddr | input | LADDR_W | Local byte address of the first descriptor (list only) |
| cmdSize | input | SIZE_W | Byte size (single) or entry count (list) |
| locReqValid | output | 1 | Local request pending |
| locReqReady | input | 1 | Local port accepts request |
| locReqWrite | output | 1 | Local request is a write |
| locReqAddr | output | LADDR_W | Local request byte address |
| locReqWdata | output | 128 | Local write data |
| locRspValid | input | 1 | Local read data or write acknowledge |
| locRspData | input | 128 | Local read data |
| remReqValid | output | 1 | Remote request pending |
| remReqReady | input | 1 | Remote port accepts request |
| remReqWrite | output | 1 | Remote request is a write |
| remReqAddr | output | RADDR_W | Remote request byte address |
| remReqWdata | output | 128 | Remote write data |
| remRspValid | input | 1 | Remote read data or write acknowledge |
| remRspData | input | 128 | Remote read data |
| doneValid | output | 1 | Completion pulse |
| doneTag | output | TAG_W | Tag of the completed command |
| doneErr | output | 1 | Command was refused or aborted |

## Verification
Single puts and gets are run at a few sizes, from one beat up to the 16 KB limit. These cases separate the two directions and show that the last beat is neither dropped nor repeated. Lists are run at the minimum and maximum entry counts, with a first descriptor in the upper half of a beat, and with a bad entry in the middle. These cases show whether the descriptor half is picked correctly, whether the local address carries over between entries, and whether an abort stops the data flow at the right entry. Each refusal rule is tried on its own, and the bench confirms that a refused command produces no port traffic at all and completes one cycle after acceptance.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  localparam int BEAT_BYTES = 16;
  localparam int BEAT_LSB   = 4;
  localparam int DATA_W     = BEAT_BYTES * 8;
  localparam int DESC_BYTES = 8;
  localparam int DESC_W     = DESC_BYTES * 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC_REQ,
    S_DESC_WAIT,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ,
    S_WR_WAIT,
    S_DONE
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic loadDesc;
    logic captureBeat;
    logic advanceBeat;
    logic nextEntry;
    logic setErr;
  } xferCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic cmdBad;
    logic descBad;
    logic lastBeat;
    logic lastEntry;
    logic isPut;
    logic isList;
  } xferSts_t;

endpackage

// File: rtl/blkxfer_datapath.sv
module blkxfer_datapath
  import blkxfer_pkg::*;
#(
  parameter int LADDR_W     = 18,
  parameter int RADDR_W     = 32,
  parameter int SIZE_W      = 15,
  parameter int TAG_W       = 4,
  parameter int MAX_BLOCK   = 16384,
  parameter int MAX_ENTRIES = 2048
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xferCtl_t             ctl,
  input  logic                 cmdPut,
  input  logic                 cmdList,
  input  logic [TAG_W-1:0]     cmdTag,
  input  logic [LADDR_W-1:0]   cmdLocalAddr,
  input  logic [RADDR_W-1:0]   cmdRemoteAddr,
  input  logic [LADDR_W-1:0]   cmdListAddr,
  input  logic [SIZE_W-1:0]    cmdSize,
  input  logic [DATA_W-1:0]    locRspData,
  input  logic [DATA_W-1:0]    remRspData,
  output xferSts_t             sts,
  output logic [LADDR_W-1:0]   localPtr,
  output logic [RADDR_W-1:0]   remotePtr,
  output logic [LADDR_W-1:0]   descBeatAddr,
  output logic [DATA_W-1:0]    beatData,
  output logic [TAG_W-1:0]     tagQ,
  output logic                 errQ
);

  localparam int ENT_W = $clog2(MAX_ENTRIES + 1);
  localparam int HALF_W = BEAT_LSB - 3;
  localparam logic [SIZE_W-1:0] MAX_BLOCK_V   = SIZE_W'(MAX_BLOCK);
  localparam logic [SIZE_W-1:0] MAX_ENTRIES_V = SIZE_W'(MAX_ENTRIES);
  localparam logic [31:0]       MAX_DESC_V    = 32'(MAX_BLOCK);

  logic [LADDR_W-1:0] listPtr;
  logic [SIZE_W-1:0]  bytesLeft;
  logic [ENT_W-1:0]   entriesLeft;
  logic               isPut;
  logic               isList;

  // issue-time checks on the offered command
  logic sizeBad, singleBad, listBad;
  always_comb begin
    sizeBad   = (cmdSize == '0) || (cmdSize > MAX_BLOCK_V) ||
                (cmdSize[BEAT_LSB-1:0] != '0);
    singleBad = sizeBad || (cmdLocalAddr[BEAT_LSB-1:0] != '0) ||
                (cmdRemoteAddr[BEAT_LSB-1:0] != '0);
    listBad   = (cmdSize < SIZE_W'(2)) || (cmdSize > MAX_ENTRIES_V) ||
                (cmdListAddr[2:0] != 3'b000) ||
                (cmdLocalAddr[BEAT_LSB-1:0] != '0);
  end

  // descriptor picked out of the returned beat
  logic [HALF_W-1:0] descHalf;
  logic [DESC_W-1:0] descWord;
  logic [31:0]       descRemote;
  logic [31:0]       descSize;
  logic              descBad;

  always_comb begin
    descHalf   = listPtr[BEAT_LSB-1:3];
    descWord   = locRspData[descHalf*DESC_W +: DESC_W];
    descRemote = descWord[31:0];
    descSize   = descWord[63:32];
    descBad    = (descSize == 32'd0) || (descSize > MAX_DESC_V) ||
                 (descSize[BEAT_LSB-1:0] != '0) ||
                 (descRemote[BEAT_LSB-1:0] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      localPtr    <= '0;
      remotePtr   <= '0;
      listPtr     <= '0;
      bytesLeft   <= '0;
      entriesLeft <= '0;
      isPut       <= 1'b0;
      isList      <= 1'b0;
      tagQ        <= '0;
      errQ        <= 1'b0;
      beatData    <= '0;
    end else begin
      if (ctl.loadCmd) begin
        localPtr    <= cmdLocalAddr;
        remotePtr   <= cmdRemoteAddr;
        listPtr     <= cmdListAddr;
        bytesLeft   <= cmdSize;
        entriesLeft <= cmdSize[ENT_W-1:0];
        isPut       <= cmdPut;
        isList      <= cmdList;
        tagQ        <= cmdTag;
        errQ        <= 1'b0;
      end
      if (ctl.setErr) begin
        errQ <= 1'b1;
      end
      if (ctl.loadDesc) begin
        remotePtr <= descRemote[RADDR_W-1:0];
        bytesLeft <= descSize[SIZE_W-1:0];
      end
      if (ctl.captureBeat) begin
        beatData <= isPut ? locRspData : remRspData;
      end
      if (ctl.advanceBeat) begin
        localPtr  <= localPtr + LADDR_W'(BEAT_BYTES);
        remotePtr <= remotePtr + RADDR_W'(BEAT_BYTES);
        bytesLeft <= bytesLeft - SIZE_W'(BEAT_BYTES);
      end
      if (ctl.nextEntry) begin
        listPtr     <= listPtr + LADDR_W'(DESC_BYTES);
        entriesLeft <= entriesLeft - ENT_W'(1);
      end
    end
  end

  always_comb begin
    sts.cmdBad    = cmdList ? listBad : singleBad;
    sts.descBad   = descBad;
    sts.lastBeat  = (bytesLeft == SIZE_W'(BEAT_BYTES));
    sts.lastEntry = (entriesLeft == ENT_W'(1));
    sts.isPut     = isPut;
    sts.isList    = isList;
    descBeatAddr  = {listPtr[LADDR_W-1:BEAT_LSB], {BEAT_LSB{1'b0}}};
  end

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     cmdList,
  input  xferSts_t sts,
  input  logic     locReqReady,
  input  logic     locRspValid,
  input  logic     remReqReady,
  input  logic     remRspValid,
  output xferCtl_t ctl,
  output logic     cmdReady,
  output logic     locReqValid,
  output logic     locReqWrite,
  output logic     remReqValid,
  output logic     remReqWrite,
  output logic     descPhase,
  output logic     doneValid
);

  xferState_t state, stateNext;

  logic srcReady, srcRsp, dstReady, dstRsp;

  always_comb begin
    srcReady = sts.isPut ? locReqReady : remReqReady;
    srcRsp   = sts.isPut ? locRspValid : remRspValid;
    dstReady = sts.isPut ? remReqReady : locReqReady;
    dstRsp   = sts.isPut ? remRspValid : locRspValid;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          ctl.loadCmd = 1'b1;
          if (sts.cmdBad) begin
            ctl.setErr = 1'b1;
            stateNext  = S_DONE;
          end else begin
            stateNext = cmdList ? S_DESC_REQ : S_RD_REQ;
          end
        end
      end
      S_DESC_REQ: begin
        if (locReqReady) stateNext = S_DESC_WAIT;
      end
      S_DESC_WAIT: begin
        if (locRspValid) begin
          if (sts.descBad) begin
            ctl.setErr = 1'b1;
            stateNext  = S_DONE;
          end else begin
            ctl.loadDesc = 1'b1;
            stateNext    = S_RD_REQ;
          end
        end
      end
      S_RD_REQ: begin
        if (srcReady) stateNext = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (srcRsp) begin
          ctl.captureBeat = 1'b1;
          stateNext       = S_WR_REQ;
        end
      end
      S_WR_REQ: begin
        if (dstReady) stateNext = S_WR_WAIT;
      end
      S_WR_WAIT: begin
        if (dstRsp) begin
          ctl.advanceBeat = 1'b1;
          if (!sts.lastBeat) begin
            stateNext = S_RD_REQ;
          end else if (sts.isList && !sts.lastEntry) begin
            ctl.nextEntry = 1'b1;
            stateNext     = S_DESC_REQ;
          end else begin
            stateNext = S_DONE;
          end
        end
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmdReady    = (state == S_IDLE);
    descPhase   = (state == S_DESC_REQ);
    locReqValid = descPhase ||
                  ((state == S_RD_REQ) && sts.isPut) ||
                  ((state == S_WR_REQ) && !sts.isPut);
    locReqWrite = (state == S_WR_REQ) && !sts.isPut;
    remReqValid = ((state == S_RD_REQ) && !sts.isPut) ||
                  ((state == S_WR_REQ) && sts.isPut);
    remReqWrite = (state == S_WR_REQ) && sts.isPut;
    doneValid   = (state == S_DONE);
  end

endmodule

// File: rtl/blkxfer.sv
module blkxfer
  import blkxfer_pkg::*;
#(
  parameter int LADDR_W     = 18,
  parameter int RADDR_W     = 32,
  parameter int SIZE_W      = 15,
  parameter int TAG_W       = 4,
  parameter int MAX_BLOCK   = 16384,
  parameter int MAX_ENTRIES = 2048
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic               cmdPut,
  input  logic               cmdList,
  input  logic [TAG_W-1:0]   cmdTag,
  input  logic [LADDR_W-1:0] cmdLocalAddr,
  input  logic [RADDR_W-1:0] cmdRemoteAddr,
  input  logic [LADDR_W-1:0] cmdListAddr,
  input  logic [SIZE_W-1:0]  cmdSize,
  output logic               locReqValid,
  input  logic               locReqReady,
  output logic               locReqWrite,
  output logic [LADDR_W-1:0] locReqAddr,
  output logic [127:0]       locReqWdata,
  input  logic               locRspValid,
  input  logic [127:0]       locRspData,
  output logic               remReqValid,
  input  logic               remReqReady,
  output logic               remReqWrite,
  output logic [RADDR_W-1:0] remReqAddr,
  output logic [127:0]       remReqWdata,
  input  logic               remRspValid,
  input  logic [127:0]       remRspData,
  output logic               doneValid,
  output logic [TAG_W-1:0]   doneTag,
  output logic               doneErr
);

  xferCtl_t           ctl;
  xferSts_t           sts;
  logic               descPhase;
  logic [LADDR_W-1:0] localPtr;
  logic [LADDR_W-1:0] descBeatAddr;
  logic [RADDR_W-1:0] remotePtr;
  logic [DATA_W-1:0]  beatData;

  blkxfer_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdList    (cmdList),
    .sts        (sts),
    .locReqReady(locReqReady),
    .locRspValid(locRspValid),
    .remReqReady(remReqReady),
    .remRspValid(remRspValid),
    .ctl        (ctl),
    .cmdReady   (cmdReady),
    .locReqValid(locReqValid),
    .locReqWrite(locReqWrite),
    .remReqValid(remReqValid),
    .remReqWrite(remReqWrite),
    .descPhase  (descPhase),
    .doneValid  (doneValid)
  );

  blkxfer_datapath #(
    .LADDR_W    (LADDR_W),
    .RADDR_W    (RADDR_W),
    .SIZE_W     (SIZE_W),
    .TAG_W      (TAG_W),
    .MAX_BLOCK  (MAX_BLOCK),
    .MAX_ENTRIES(MAX_ENTRIES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .cmdPut       (cmdPut),
    .cmdList      (cmdList),
    .cmdTag       (cmdTag),
    .cmdLocalAddr (cmdLocalAddr),
    .cmdRemoteAddr(cmdRemoteAddr),
    .cmdListAddr  (cmdListAddr),
    .cmdSize      (cmdSize),
    .locRspData   (locRspData),
    .remRspData   (remRspData),
    .sts          (sts),
    .localPtr     (localPtr),
    .remotePtr    (remotePtr),
    .descBeatAddr (descBeatAddr),
    .beatData     (beatData),
    .tagQ         (doneTag),
    .errQ         (doneErr)
  );

  assign locReqAddr  = descPhase ? descBeatAddr : localPtr;
  assign locReqWdata = beatData;
  assign remReqAddr  = remotePtr;
  assign remReqWdata = beatData;

endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int LADDR_W = 18,
  parameter int RADDR_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic               locReqValid,
  input logic               locReqReady,
  input logic               locReqWrite,
  input logic [LADDR_W-1:0] locReqAddr,
  input logic               remReqValid,
  input logic               remReqReady,
  input logic               remReqWrite,
  input logic [RADDR_W-1:0] remReqAddr,
  input logic               doneValid
);

  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(locReqValid && remReqValid));

  // R10
  loc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locReqValid && !locReqReady) |=>
      (locReqValid && $stable(locReqAddr) && $stable(locReqWrite)));

  // R10
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remReqValid && !remReqReady) |=>
      (remReqValid && $stable(remReqAddr) && $stable(remReqWrite)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R1
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> cmdReady);

  // R2
  rem_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    remReqValid |-> (remReqAddr[3:0] == 4'h0));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!rstN |-> (cmdReady && !locReqValid && !remReqValid && !doneValid)));

endmodule

bind blkxfer blkxfer_chk #(
  .LADDR_W(LADDR_W),
  .RADDR_W(RADDR_W)
) chk_i (.*);

// File: tb/blkxfer_tb_top.sv
module blkxfer_tb_top;

  localparam int LADDR_W = 18;
  localparam int RADDR_W = 32;
  localparam int SIZE_W  = 15;
  localparam int TAG_W   = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cmdValid = 1'b0;
  logic               cmdReady;
  logic               cmdPut = 1'b0;
  logic               cmdList = 1'b0;
  logic [TAG_W-1:0]   cmdTag = '0;
  logic [LADDR_W-1:0] cmdLocalAddr = '0;
  logic [RADDR_W-1:0] cmdRemoteAddr = '0;
  logic [LADDR_W-1:0] cmdListAddr = '0;
  logic [SIZE_W-1:0]  cmdSize = '0;
  logic               locReqValid, locReqWrite;
  logic               locReqReady = 1'b0;
  logic [LADDR_W-1:0] locReqAddr;
  logic [127:0]       locReqWdata;
  logic               locRspValid = 1'b0;
  logic [127:0]       locRspData = '0;
  logic               remReqValid, remReqWrite;
  logic               remReqReady = 1'b0;
  logic [RADDR_W-1:0] remReqAddr;
  logic [127:0]       remReqWdata;
  logic               remRspValid = 1'b0;
  logic [127:0]       remRspData = '0;
  logic               doneValid, doneErr;
  logic [TAG_W-1:0]   doneTag;

  always #2 clk = ~clk;

  blkxfer dut_i (.*);

  // ---------------- memory models ----------------
  logic [127:0] locMem [int];
  logic [127:0] remMem [int];
  int cyc = 0;

  function automatic logic [127:0] patt(input bit side, input int a);
    return {a ^ (side ? 32'hC3C3_0000 : 32'h3C3C_0000), ~a, a * 7, 32'h5EED_0000 | 32'(side)};
  endfunction

  function automatic logic [127:0] locRead(input int a);
    return locMem.exists(a) ? locMem[a] : patt(1'b0, a);
  endfunction

  function automatic logic [127:0] remRead(input int a);
    return remMem.exists(a) ? remMem[a] : patt(1'b1, a);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    locRspValid <= 1'b0;
    remRspValid <= 1'b0;
    if (locReqValid && locReqReady) begin
      if (locReqWrite) locMem[int'(locReqAddr)] = locReqWdata;
      locRspValid <= 1'b1;
      locRspData  <= locRead(int'(locReqAddr));
    end
    if (remReqValid && remReqReady) begin
      if (remReqWrite) remMem[int'(remReqAddr)] = remReqWdata;
      remRspValid <= 1'b1;
      remRspData  <= remRead(int'(remReqAddr));
    end
    locReqReady <= (cyc % 3) != 1;
    remReqReady <= (cyc % 4) != 2;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit           toLocal;
    int           addr;
    logic [127:0] data;
    string        rq;
  } wrExp_t;

  typedef struct {
    logic [TAG_W-1:0] tag;
    bit               err;
    string            rq;
  } doneExp_t;

  wrExp_t   wrQ[$];
  doneExp_t doneQ[$];
  int checks = 0;
  int fails = 0;
  int busCount = 0;
  int dualReq = 0;
  bit timedOut = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic seeWrite(input bit toLocal, input int a, input logic [127:0] d);
    wrExp_t e;
    if (wrQ.size() == 0) begin
      chk(1'b0, "R8", "unexpected write", 128'(a), 128'(0));
    end else begin
      e = wrQ.pop_front();
      chk(toLocal == e.toLocal, e.rq, "write port", 128'(toLocal), 128'(e.toLocal));
      chk(a == e.addr, e.rq, "write address", 128'(a), 128'(e.addr));
      chk(d == e.data, e.rq, "write data", d, e.data);
    end
  endtask

  always @(negedge clk) begin
    if (locReqValid && locReqReady) busCount++;
    if (remReqValid && remReqReady) busCount++;
    if (locReqValid && remReqValid) dualReq++;
    if (locReqValid && locReqReady && locReqWrite) seeWrite(1'b1, int'(locReqAddr), locReqWdata);
    if (remReqValid && remReqReady && remReqWrite) seeWrite(1'b0, int'(remReqAddr), remReqWdata);
    if (doneValid) begin
      if (doneQ.size() == 0) begin
        chk(1'b0, "R9", "unexpected completion", 128'(doneTag), 128'(0));
      end else begin
        doneExp_t d;
        d = doneQ.pop_front();
        chk(doneTag == d.tag, d.rq, "done tag", 128'(doneTag), 128'(d.tag));
        chk(doneErr == d.err, d.rq, "done error", 128'(doneErr), 128'(d.err));
      end
    end
    if (cyc > 150000 && !timedOut) begin
      timedOut = 1'b1;
      chk(1'b0, "R9", "watchdog expired", 128'(cyc), 128'(0));
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- driver ----------------
  task automatic setDesc(input int listA, input int idx, input int rAddr, input int sz);
    int a, w;
    logic [127:0] cur;
    a = listA + 8 * idx;
    w = a & ~15;
    cur = locRead(w);
    if (a[3]) cur[127:64] = {sz, rAddr};
    else      cur[63:0]   = {sz, rAddr};
    locMem[w] = cur;
  endtask

  task automatic pushBeats(input bit put, input int la, input int ra, input int sz, input string rq);
    for (int k = 0; k < sz / 16; k++) begin
      wrExp_t e;
      e.rq = rq;
      if (put) begin
        e.toLocal = 1'b0; e.addr = ra + 16 * k; e.data = locRead(la + 16 * k);
      end else begin
        e.toLocal = 1'b1; e.addr = la + 16 * k; e.data = remRead(ra + 16 * k);
      end
      wrQ.push_back(e);
    end
  endtask

  task automatic runCmd(input bit put, input bit list, input int la, input int ra,
                        input int lista, input int sz, input int tag,
                        input bit issueRej, input bit expErr, input string rq);
    doneExp_t d;
    int busBefore;
    if (!issueRej) begin
      if (!list) begin
        pushBeats(put, la, ra, sz, rq);
      end else begin
        int lp;
        lp = la;
        for (int i = 0; i < sz; i++) begin
          int a;
          logic [63:0] dw;
          logic [127:0] bw;
          int dr, ds;
          a = lista + 8 * i;
          bw = locRead(a & ~15);
          dw = a[3] ? bw[127:64] : bw[63:0];
          dr = dw[31:0];
          ds = dw[63:32];
          if (ds == 0 || ds > 16384 || ds[3:0] != 0 || dr[3:0] != 0) break;
          pushBeats(put, lp, dr, ds, rq);
          lp += ds;
        end
      end
    end
    d.tag = TAG_W'(tag); d.err = expErr; d.rq = rq;
    doneQ.push_back(d);

    @(negedge clk);
    busBefore     = busCount;
    cmdValid      = 1'b1;
    cmdPut        = put;
    cmdList       = list;
    cmdTag        = TAG_W'(tag);
    cmdLocalAddr  = LADDR_W'(la);
    cmdRemoteAddr = RADDR_W'(ra);
    cmdListAddr   = LADDR_W'(lista);
    cmdSize       = SIZE_W'(sz);
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    // R1: busy right after acceptance
    chk(cmdReady == 1'b0, "R1", "ready after accept", 128'(cmdReady), 128'(0));
    if (issueRej) begin
      // R4 / R5: refusal completes one cycle after acceptance
      chk(doneValid && doneErr, rq, "immediate refusal", 128'({doneValid, doneErr}), 128'(3));
    end else begin
      chk(doneValid == 1'b0, rq, "no early completion", 128'(doneValid), 128'(0));
    end
    while (doneQ.size() != 0 && !timedOut) @(negedge clk);
    // R9: all writes seen before completion
    chk(wrQ.size() == 0, "R9", "writes left at completion", 128'(wrQ.size()), 128'(0));
    if (issueRej)
      chk(busCount == busBefore, rq, "port traffic on refusal", 128'(busCount - busBefore), 128'(0));
    @(negedge clk);
    chk(cmdReady == 1'b1, "R1", "ready after completion", 128'(cmdReady), 128'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cmdReady == 1'b1, "R11", "cmdReady in reset", 128'(cmdReady), 128'(1));
    chk(!locReqValid && !remReqValid, "R11", "requests in reset",
        128'({locReqValid, remReqValid}), 128'(0));
    chk(doneValid == 1'b0, "R11", "doneValid in reset", 128'(doneValid), 128'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // single transfers
    runCmd(1'b1, 1'b0, 32'h100, 32'h1000_0000, 0, 64, 1, 1'b0, 1'b0, "R2");
    runCmd(1'b0, 1'b0, 32'h800, 32'h2000_0040, 0, 48, 2, 1'b0, 1'b0, "R3");
    runCmd(1'b1, 1'b0, 32'h10000, 32'h3000_0000, 0, 16384, 3, 1'b0, 1'b0, "R2");
    runCmd(1'b0, 1'b0, 32'hC00, 32'h2100_0000, 0, 16, 4, 1'b0, 1'b0, "R3");

    // single refusals
    runCmd(1'b1, 1'b0, 32'h100, 32'h1000_0000, 0, 0, 5, 1'b1, 1'b1, "R4");
    runCmd(1'b1, 1'b0, 32'h100, 32'h1000_0000, 0, 16400, 6, 1'b1, 1'b1, "R4");
    runCmd(1'b0, 1'b0, 32'h100, 32'h1000_0000, 0, 24, 7, 1'b1, 1'b1, "R4");
    runCmd(1'b1, 1'b0, 32'h108, 32'h1000_0000, 0, 32, 8, 1'b1, 1'b1, "R4");
    runCmd(1'b0, 1'b0, 32'h100, 32'h1000_0008, 0, 32, 9, 1'b1, 1'b1, "R4");

    // R6 / R7: get list, first entry in the upper half of a beat
    setDesc(32'h2008, 0, 32'h4000_0100, 32);
    setDesc(32'h2008, 1, 32'h4100_0000, 16);
    setDesc(32'h2008, 2, 32'h4200_0200, 48);
    runCmd(1'b0, 1'b1, 32'h4000, 0, 32'h2008, 3, 10, 1'b0, 1'b0, "R6");

    // R5 / R7: put list at minimum length
    setDesc(32'h2100, 0, 32'h5000_0000, 32);
    setDesc(32'h2100, 1, 32'h5100_0010, 16);
    runCmd(1'b1, 1'b1, 32'h4400, 0, 32'h2100, 2, 11, 1'b0, 1'b0, "R7");

    // R5 refusals
    runCmd(1'b1, 1'b1, 32'h4400, 0, 32'h2100, 1, 12, 1'b1, 1'b1, "R5");
    runCmd(1'b1, 1'b1, 32'h4400, 0, 32'h2100, 2049, 13, 1'b1, 1'b1, "R5");
    runCmd(1'b1, 1'b1, 32'h4400, 0, 32'h2104, 2, 14, 1'b1, 1'b1, "R5");
    runCmd(1'b1, 1'b1, 32'h4408, 0, 32'h2100, 2, 15, 1'b1, 1'b1, "R5");

    // R8: bad second descriptor aborts
    setDesc(32'h2200, 0, 32'h6000_0000, 32);
    setDesc(32'h2200, 1, 32'h6100_0000, 24);
    setDesc(32'h2200, 2, 32'h6200_0000, 16);
    runCmd(1'b0, 1'b1, 32'h4800, 0, 32'h2200, 3, 1, 1'b0, 1'b1, "R8");

    // R5 maximum list length
    for (int i = 0; i < 2048; i++) setDesc(32'h8000, i, 32'h7000_0000 + 32 * i, 16);
    runCmd(1'b1, 1'b1, 32'h20000, 0, 32'h8000, 2048, 2, 1'b0, 1'b0, "R5");

    // R10: never two ports requesting at once
    chk(dualReq == 0, "R10", "cycles with both ports requesting", 128'(dualReq), 128'(0));

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule